// File: doc/BRIEF.md
# Ethernet MAC-side interface adapter

This block joins a 10 Mb/s serial Ethernet controller to the internal transmit and receive paths of one media channel. On the transmit side it halves the master oscillator to produce the transmit clock for the controller. On each rising edge of that clock it takes one transmit bit, but only while transmit enable is high, and passes the bit to the encoder as a one-cycle strobe. On the receive side it takes five indications from the decoder: packet valid, recovered clock, recovered data, clock lock and end of packet. From these it drives carrier sense, receive data and receive clock toward the controller. A collision indication is forwarded as the collision output.

Controllers from different families expect different idle levels and different clock behaviour around a packet. A static two-bit controller-type input selects these. It sets the idle level of receive data and whether the receive clock copies the transmit clock while idle or is held low. A small state machine moves the receive clock between its idle source and the recovered clock. Each move happens only in a cycle where both sources are low, so no high pulse is ever cut short.

All clocks are modelled as levels or one-cycle enables on a single fast system clock. The master oscillator is a tick input that is high one cycle in two. The receive state machine has five states:
- RX_IDLE: no packet.
- RX_CARRIER: packet seen, clock not yet locked.
- RX_SWITCH_IN: lock seen, waiting for both clock sources to be low.
- RX_LOCKED: receive clock taken from the recovered clock.
- RX_SWITCH_OUT: packet ended, waiting for both sources to be low before going back to the idle source.

The transitions are:
- RX_IDLE to RX_CARRIER on packet valid.
- RX_CARRIER to RX_SWITCH_IN on lock.
- RX_CARRIER to RX_IDLE on end of packet.
- RX_SWITCH_IN to RX_LOCKED when both sources are low.
- RX_SWITCH_IN to RX_IDLE on end of packet.
- RX_LOCKED to RX_SWITCH_OUT on end of packet.
- RX_SWITCH_OUT to RX_IDLE when both sources are low.

Top module: `mac_side_adapter`

## Requirements
- R1: `txc` toggles one cycle after every cycle in which `osc_tick` is high, and at no other time. It therefore runs at half the oscillator rate.
- R2: `enc_valid` is high for exactly one cycle, in the cycle where `txc` has just risen, if `tx_en` was high at that edge. `enc_data` then carries the `tx_data` bit sampled at that edge. In every other cycle, including all cycles where `tx_en` was low, `enc_valid` and `enc_data` are 0.
- R3: `crs` rises one cycle after `pkt_valid` is seen in idle, before any lock. It falls one cycle after `eop`.
- R4: `rxd` holds the idle level whenever the receive clock is not taken from the recovered clock. The idle level is 1 for `ctl_mode` = 1 and 0 for `ctl_mode` = 0, 2 and 3. `rxd` returns to this level two cycles after `eop`.
- R5: While idle or before lock, `rxc` has one of two values:
  - for `ctl_mode` = 0, the value `txc` had one cycle earlier;
  - for `ctl_mode` = 1, 2 and 3, constant 0.
- R6: After `rec_lock`, `rxc` moves to `rec_clk`, delayed by one cycle. The move happens only in a cycle where both sources are low. As a result, no high pulse on `rxc` is shorter than the shortest high phase of the source it came from.
- R7: While locked, `rxd` loads `rec_data` on each falling edge of `rec_clk`. The load appears in the same cycle in which `rxc` falls. `rxd` changes at no other time during the packet.
- R8: After `eop`, `rxc` returns to its idle source in a cycle where both sources are low. The block then accepts the next packet.
- R9: `col` equals `col_in` delayed by one cycle, in every state and mode.
- R10: If `eop` arrives before `rec_lock`, the block returns to idle at once and `rxc` never shows `rec_clk`.
- R11: During reset, `txc`, `enc_valid`, `enc_data`, `crs`, `col` and `rxc` are 0, and `rxd` is at the idle level of the current mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_tick | input | 1 | One-cycle marker of a master-oscillator edge |
| ctl_mode | input | 2 | Static controller-type selection |
| tx_en | input | 1 | Transmit enable from controller |
| tx_data | input | 1 | Serial transmit data from controller |
| txc | output | 1 | Transmit clock to controller |
| enc_valid | output | 1 | Strobe for one accepted transmit bit |
| enc_data | output | 1 | Accepted transmit bit toward encoder |
| pkt_valid | input | 1 | Decoder reports a valid packet |
| rec_lock | input | 1 | Clock recovery has locked |
| rec_clk | input | 1 | Recovered clock level |
| rec_data | input | 1 | Recovered NRZ data |
| eop | input | 1 | End-of-packet pulse |
| col_in | input | 1 | Collision indication |
| crs | output | 1 | Carrier sense to controller |
| col | output | 1 | Collision to controller |
| rxd | output | 1 | Receive data to controller |
| rxc | output | 1 | Receive clock to controller |

## Verification
Two events can fall in the same cycle. The first is a change of the collision indication. The second is a clock handover or the last data load before end of packet. Collision toggles at random throughout every packet, so it regularly lands on a switch cycle or on the `eop` cycle. The bench judges `col` in every cycle against the delayed input. In the same run it checks that every `rxc` high pulse keeps its full width and that each `rxd` change coincides with a falling `rxc`. The recovered clock starts at a random phase against `txc`, so the handover point moves from packet to packet in all four modes.

// File: rtl/mac_adapt_pkg.sv
package mac_adapt_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [2:0] {
        RX_IDLE       = 3'd0,
        RX_CARRIER    = 3'd1,
        RX_SWITCH_IN  = 3'd2,
        RX_LOCKED     = 3'd3,
        RX_SWITCH_OUT = 3'd4
    } rx_state_t;

    // Idle level of receive data for a controller type.
    function automatic logic idle_rxd_level(input logic [MODE_W-1:0] mode);
        return mode == MODE_W'(1);
    endfunction

    // Whether the idle receive clock copies the transmit clock.
    function automatic logic idle_clk_follows(input logic [MODE_W-1:0] mode);
        return mode == MODE_W'(0);
    endfunction

endpackage

// File: rtl/mac_tx_clkgen.sv
module mac_tx_clkgen #(
    parameter int OSC_PER_HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic tx_en,
    input  logic tx_data,
    output logic txc,
    output logic enc_valid,
    output logic enc_data
);

    logic half_done;

    generate
        if (OSC_PER_HALF == 1) begin : g_direct
            assign half_done = osc_tick;
        end else begin : g_count
            localparam int CNT_W = $clog2(OSC_PER_HALF);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSC_PER_HALF - 1);
            logic [CNT_W-1:0] osc_cnt;

            assign half_done = osc_tick && (osc_cnt == CNT_LAST);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    osc_cnt <= '0;
                end else if (osc_tick) begin
                    osc_cnt <= half_done ? '0 : osc_cnt + CNT_W'(1);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txc       <= 1'b0;
            enc_valid <= 1'b0;
            enc_data  <= 1'b0;
        end else begin
            enc_valid <= 1'b0;
            enc_data  <= 1'b0;
            if (half_done) begin
                txc <= ~txc;
                // A low-to-high transition of txc is the sampling edge.
                if (!txc && tx_en) begin
                    enc_valid <= 1'b1;
                    enc_data  <= tx_data;
                end
            end
        end
    end

endmodule

// File: rtl/mac_rx_fsm.sv
module mac_rx_fsm
    import mac_adapt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pkt_valid,
    input  logic      rec_lock,
    input  logic      eop,
    input  logic      rec_clk,
    input  logic      idle_clk,
    output rx_state_t state
);

    rx_state_t state_n;
    logic      both_low;

    assign both_low = !rec_clk && !idle_clk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE: begin
                if (pkt_valid) state_n = RX_CARRIER;
            end
            RX_CARRIER: begin
                if (eop)           state_n = RX_IDLE;
                else if (rec_lock) state_n = RX_SWITCH_IN;
            end
            RX_SWITCH_IN: begin
                if (eop)           state_n = RX_IDLE;
                else if (both_low) state_n = RX_LOCKED;
            end
            RX_LOCKED: begin
                if (eop) state_n = RX_SWITCH_OUT;
            end
            RX_SWITCH_OUT: begin
                if (both_low) state_n = RX_IDLE;
            end
            default: state_n = RX_IDLE;
        endcase
    end

endmodule

// File: rtl/mac_rx_drive.sv
module mac_rx_drive
    import mac_adapt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] ctl_mode,
    input  rx_state_t         state,
    input  logic              rec_clk,
    input  logic              rec_data,
    input  logic              idle_clk,
    input  logic              col_in,
    output logic              crs,
    output logic              col,
    output logic              rxd,
    output logic              rxc
);

    logic rec_q;
    logic use_rec;
    logic rec_fall;

    assign use_rec  = (state == RX_LOCKED) || (state == RX_SWITCH_OUT);
    assign rec_fall = rec_q && !rec_clk;

    always_comb begin
        unique case (state)
            RX_CARRIER, RX_SWITCH_IN, RX_LOCKED: crs = 1'b1;
            default:                             crs = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= 1'b0;
            col   <= 1'b0;
            rxc   <= 1'b0;
            rxd   <= idle_rxd_level(ctl_mode);
        end else begin
            rec_q <= rec_clk;
            col   <= col_in;
            rxc   <= use_rec ? rec_clk : idle_clk;
            if (state == RX_LOCKED) begin
                if (rec_fall) rxd <= rec_data;
            end else begin
                rxd <= idle_rxd_level(ctl_mode);
            end
        end
    end

endmodule

// File: rtl/mac_side_adapter.sv
module mac_side_adapter
    import mac_adapt_pkg::*;
#(
    parameter int OSC_PER_HALF = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [MODE_W-1:0] ctl_mode,
    input  logic              tx_en,
    input  logic              tx_data,
    output logic              txc,
    output logic              enc_valid,
    output logic              enc_data,
    input  logic              pkt_valid,
    input  logic              rec_lock,
    input  logic              rec_clk,
    input  logic              rec_data,
    input  logic              eop,
    input  logic              col_in,
    output logic              crs,
    output logic              col,
    output logic              rxd,
    output logic              rxc
);

    rx_state_t rx_state;
    logic      idle_clk;

    assign idle_clk = idle_clk_follows(ctl_mode) ? txc : 1'b0;

    mac_tx_clkgen #(
        .OSC_PER_HALF(OSC_PER_HALF)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .tx_en     (tx_en),
        .tx_data   (tx_data),
        .txc       (txc),
        .enc_valid (enc_valid),
        .enc_data  (enc_data)
    );

    mac_rx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .rec_lock  (rec_lock),
        .eop       (eop),
        .rec_clk   (rec_clk),
        .idle_clk  (idle_clk),
        .state     (rx_state)
    );

    mac_rx_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_mode (ctl_mode),
        .state    (rx_state),
        .rec_clk  (rec_clk),
        .rec_data (rec_data),
        .idle_clk (idle_clk),
        .col_in   (col_in),
        .crs      (crs),
        .col      (col),
        .rxd      (rxd),
        .rxc      (rxc)
    );

endmodule

// File: rtl/mac_side_adapter_chk.sv
module mac_side_adapter_chk
    import mac_adapt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              osc_tick,
    input logic [MODE_W-1:0] ctl_mode,
    input logic              tx_en,
    input logic              txc,
    input logic              enc_valid,
    input logic              pkt_valid,
    input logic              crs,
    input logic              col_in,
    input logic              col,
    input logic              rxc,
    input logic              rxd,
    input rx_state_t         state
);

    a_r1_txc_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txc) |-> $past(osc_tick));

    a_r2_sample_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> $past(tx_en));

    a_r2_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> $rose(txc));

    a_r3_crs_needs_packet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crs) |-> $past(pkt_valid));

    a_r4_rxd_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RX_LOCKED && $past(state) != RX_LOCKED) |-> rxd == idle_rxd_level(ctl_mode));

    a_r5_rxc_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !idle_clk_follows(ctl_mode)) |-> !rxc);

    a_r6_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_LOCKED && $past(state) == RX_SWITCH_IN) |-> !rxc);

    a_r8_leave_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && $past(state) == RX_SWITCH_OUT) |-> !rxc);

    a_r9_col_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> col == $past(col_in));

endmodule

bind mac_side_adapter mac_side_adapter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .ctl_mode  (ctl_mode),
    .tx_en     (tx_en),
    .txc       (txc),
    .enc_valid (enc_valid),
    .pkt_valid (pkt_valid),
    .crs       (crs),
    .col_in    (col_in),
    .col       (col),
    .rxc       (rxc),
    .rxd       (rxd),
    .state     (rx_state)
);

// File: tb/mac_side_adapter_bench.sv
module mac_side_adapter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int REC_HALF   = 3;
    localparam int MIN_HIGH   = 2;
    localparam int SEED       = 7411;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [1:0] ctl_mode = 2'd0;
    logic       tx_en = 1'b0, tx_data = 1'b0;
    logic       pkt_valid = 1'b0, rec_lock = 1'b0, rec_clk = 1'b0, rec_data = 1'b0;
    logic       eop = 1'b0, col_in = 1'b0;
    logic       txc, enc_valid, enc_data, crs, col, rxd, rxc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0, mon_quiet = 1'b0, mon_carrier = 1'b0, mon_data = 1'b0;
    bit rec_run = 1'b0;

    mac_side_adapter u_mac_side_adapter (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ctl_mode(ctl_mode),
        .tx_en(tx_en), .tx_data(tx_data), .txc(txc), .enc_valid(enc_valid),
        .enc_data(enc_data), .pkt_valid(pkt_valid), .rec_lock(rec_lock),
        .rec_clk(rec_clk), .rec_data(rec_data), .eop(eop), .col_in(col_in),
        .crs(crs), .col(col), .rxd(rxd), .rxc(rxc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_idle_rxd(input logic [1:0] m);
        return m == 2'd1;
    endfunction

    function automatic logic exp_idle_rxc(input logic [1:0] m, input logic prev_txc);
        return (m == 2'd0) ? prev_txc : 1'b0;
    endfunction

    // Stimulus drivers: all inputs change 2 time units after a rising edge.
    initial begin : osc_drv
        forever begin
            @(posedge clk); #2;
            osc_tick = ~osc_tick;
        end
    end

    initial begin : rec_drv
        int ph;
        ph = 0;
        void'($urandom(SEED + 1));
        forever begin
            @(posedge clk); #2;
            if (rec_run || rec_clk) begin
                ph++;
                if (ph >= REC_HALF) begin
                    ph = 0;
                    rec_clk = ~rec_clk;
                    if (rec_clk) rec_data = ($urandom % 2) != 0;
                end
            end else begin
                ph = $urandom % REC_HALF;
            end
        end
    end

    initial begin : misc_drv
        void'($urandom(SEED + 2));
        forever begin
            @(posedge clk); #2;
            if ($urandom % 4 == 0) tx_en = ~tx_en;
            tx_data = ($urandom % 2) != 0;
            if ($urandom % 6 == 0) col_in = ~col_in;
        end
    end

    // Per-cycle monitor, sampling at the falling edge.
    logic p_rst = 1'b0, p_txc = 1'b0, p_tx_en = 1'b0, p_tx_data = 1'b0;
    logic p_osc = 1'b0, p_col_in = 1'b0, p_rec_data = 1'b0, q_rxc = 1'b0, q_rxd = 1'b0;
    int   hi_run = 0;

    always @(negedge clk) begin
        if (mon_on && rst_n && p_rst) begin
            logic ev_exp;
            ev_exp = !p_txc && txc && p_tx_en;
            chk((txc != p_txc) == p_osc, "R1 txc toggle", int'(txc), int'(p_osc ? ~p_txc : p_txc));
            chk(enc_valid == ev_exp, "R2 enc_valid", int'(enc_valid), int'(ev_exp));
            chk(enc_data == (ev_exp & p_tx_data), "R2 enc_data", int'(enc_data), int'(ev_exp & p_tx_data));
            chk(col == p_col_in, "R9 col delay", int'(col), int'(p_col_in));
            if (!rxc && q_rxc)
                chk(hi_run >= MIN_HIGH, "R6 rxc high width", hi_run, MIN_HIGH);
            if (mon_quiet || mon_carrier) begin
                chk(crs == mon_carrier, "R3 crs level", int'(crs), int'(mon_carrier));
                chk(rxd == exp_idle_rxd(ctl_mode), "R4 rxd idle", int'(rxd), int'(exp_idle_rxd(ctl_mode)));
                chk(rxc == exp_idle_rxc(ctl_mode, p_txc), "R5 rxc idle source (R8 R10)",
                    int'(rxc), int'(exp_idle_rxc(ctl_mode, p_txc)));
            end
            if (mon_data) begin
                if (rxd != q_rxd)
                    chk(q_rxc && !rxc, "R7 rxd changes only at rxc fall", int'(rxc), 0);
                if (q_rxc && !rxc)
                    chk(rxd == p_rec_data, "R7 rxd data", int'(rxd), int'(p_rec_data));
                chk(crs == 1'b1, "R3 crs held in packet", int'(crs), 1);
            end
        end
        if (!rst_n) hi_run = 0;
        else if (rxc) hi_run = (q_rxc ? hi_run : 0) + 1;
        p_rst = rst_n;  p_txc = txc;  p_tx_en = tx_en;  p_tx_data = tx_data;
        p_osc = osc_tick;  p_col_in = col_in;  p_rec_data = rec_data;
        q_rxc = rxc;  q_rxd = rxd;
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic packet(input int nbits);
        mon_quiet = 1'b0;
        pkt_valid = 1'b1;
        rec_run   = 1'b1;
        @(posedge clk); #3;
        chk(crs == 1'b1, "R3 crs before lock", int'(crs), 1);
        mon_carrier = 1'b1;
        cyc(3 + int'($urandom % 4));
        rec_lock    = 1'b1;
        mon_carrier = 1'b0;
        cyc(12);
        mon_data = 1'b1;
        cyc(nbits * 2 * REC_HALF);
        mon_data  = 1'b0;
        eop       = 1'b1;
        pkt_valid = 1'b0;
        rec_lock  = 1'b0;
        @(posedge clk); #3;
        chk(crs == 1'b0, "R3 crs drop after eop", int'(crs), 0);
        eop = 1'b0;
        @(posedge clk); #3;
        chk(rxd == exp_idle_rxd(ctl_mode), "R4 rxd idle after eop", int'(rxd), int'(exp_idle_rxd(ctl_mode)));
        cyc(14);
        rec_run = 1'b0;
        cyc(8);
        chk(crs == 1'b0, "R8 idle after packet", int'(crs), 0);
        mon_quiet = 1'b1;
        cyc(16);
    endtask

    task automatic early_packet();
        mon_quiet = 1'b0;
        pkt_valid = 1'b1;
        rec_run   = 1'b1;
        @(posedge clk); #3;
        chk(crs == 1'b1, "R10 crs on short packet", int'(crs), 1);
        mon_carrier = 1'b1;
        cyc(4);
        mon_carrier = 1'b0;
        eop       = 1'b1;
        pkt_valid = 1'b0;
        @(posedge clk); #3;
        chk(crs == 1'b0, "R10 crs drop before lock", int'(crs), 0);
        eop       = 1'b0;
        mon_quiet = 1'b1;
        cyc(20);
        rec_run = 1'b0;
        cyc(6);
    endtask

    task automatic run_mode(input logic [1:0] m);
        mon_on    = 1'b0;
        mon_quiet = 1'b0;
        rst_n     = 1'b0;
        ctl_mode  = m;
        repeat (3) @(posedge clk);
        #3;
        chk(txc == 1'b0, "R11 txc reset", int'(txc), 0);
        chk(enc_valid == 1'b0 && enc_data == 1'b0, "R11 encoder reset", int'(enc_valid), 0);
        chk(crs == 1'b0 && col == 1'b0, "R11 crs/col reset", int'(crs | col), 0);
        chk(rxc == 1'b0, "R11 rxc reset", int'(rxc), 0);
        chk(rxd == exp_idle_rxd(m), "R11 rxd reset", int'(rxd), int'(exp_idle_rxd(m)));
        @(posedge clk); #2;
        rst_n     = 1'b1;
        mon_on    = 1'b1;
        mon_quiet = 1'b1;
        cyc(20);
        for (int k = 0; k < 3; k++) packet(6 + int'($urandom % 10));
        early_packet();
        packet(5);
        mon_quiet = 1'b1;
        cyc(10);
    endtask

    initial begin : main
        void'($urandom(SEED));
        for (int m = 0; m < 4; m++) run_mode(2'(m));
        done = 1'b1;
        mon_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule